// File: doc/BRIEF.md
# Operand Pairing Stage with Frame-Slot Presence Bits

This stage sits between instruction fetch and the ALU of a token-driven pipeline. Each incoming token carries a frame pointer, an instruction pointer and a data value. It also carries the fields that the fetched instruction supplies: a slot offset, an absolute-address flag and a pairing mode. The stage turns these into a frame-slot address. It then does one read-modify-write access to frame memory and to a bit that marks whether that slot holds a value.

Depending on the mode and the slot's bit, the token is absorbed or forwarded. An absorbed token has its value parked in the slot and no ALU operation is issued. A forwarded token sends a left/right operand pair to the ALU, along with the token's tag. Each mode is a different pairing discipline: pass-through, pair-and-consume, pair-and-keep, swap, and direct store/fetch. Only one value of storage is needed per two-input instruction.

The stage has no hazard detection. Software must leave at least one idle cycle between two tokens that address the same slot.

Top module: `opnd_match_stage`

## Requirements
- R1: When `inAbs` is 1 the slot address is `inOffset`. When it is 0 the slot address is (`inFp` + `inOffset`) modulo the number of slots (64 by default).
- R2: A token accepted at a clock edge produces its result at the second following edge. The result is a one-cycle pulse on exactly one of `aluValid` and `tokKill`.
- R3: Mode code 0 (unary), and the unused codes 5 to 7, forward the token with the partner operand equal to zero. They leave the slot value and its presence bit unchanged.
- R4: Mode code 1 (normal) with the slot's bit clear stores the value, sets the bit and pulses `tokKill`.
- R5: Mode code 1 with the bit set forwards the stored value together with the incoming value and clears the bit. The next arrival at that slot is stored again.
- R6: `inPort` 0 places the incoming value on `aluOpA` (left) and the partner on `aluOpB`. `inPort` 1 places the incoming value on `aluOpB` and the partner on `aluOpA`.
- R7: Mode code 2 (sticky) stores and kills when the bit is clear. When the bit is set it forwards with the stored value and keeps the bit set, so the same value pairs with every later arrival.
- R8: Mode code 3 (exchange) always forwards the incoming value paired with the slot's previous content. It leaves the incoming value in the slot with the bit set.
- R9: Mode code 4 (imperative) with port 0 writes the slot, sets the bit and kills, whatever the bit was. With port 1 it forwards the slot's content paired with the incoming value, whatever the bit was, and leaves the bit unchanged.
- R10: Reset clears every presence bit and holds `aluValid` and `tokKill` low.
- R11: A forwarded result carries the token's frame pointer and instruction pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A token is presented this cycle |
| inFp | input | SLOT_W | Frame pointer of the token |
| inIp | input | IP_W | Instruction pointer (tag) of the token |
| inPort | input | 1 | Operand side: 0 left, 1 right |
| inValue | input | DATA_W | Token data value |
| inOffset | input | SLOT_W | Slot offset from the instruction |
| inAbs | input | 1 | 1 selects absolute addressing, 0 frame-relative |
| inMode | input | 3 | Pairing mode code |
| aluValid | output | 1 | Operand pair issued to the ALU |
| aluOpA | output | DATA_W | Left operand |
| aluOpB | output | DATA_W | Right operand |
| aluFp | output | SLOT_W | Frame pointer of the issued token |
| aluIp | output | IP_W | Instruction pointer of the issued token |
| tokKill | output | 1 | Token was absorbed into the frame |

## Verification
Each pairing mode is tested with sequences of two or three tokens to one slot. The sequences separate keep-after-match (sticky) from consume-after-match (normal), and swap (exchange) from plain store. Each mode is run with left-first and right-first arrivals, which shows that operand placement follows the port and not the arrival order. Imperative and unary tokens are followed by a normal token to the same slot. The normal token shows, through its kill or forward outcome and its partner value, whether the earlier token changed the presence bit or the stored value. Frame-relative addresses, including one that wraps past the top of the frame, are paired against absolute addresses that name the same slot.

// File: rtl/opm_pkg.sv
package opm_pkg;

  typedef enum logic [2:0] {
    MODE_UNARY      = 3'd0,
    MODE_NORMAL     = 3'd1,
    MODE_STICKY     = 3'd2,
    MODE_EXCHANGE   = 3'd3,
    MODE_IMPERATIVE = 3'd4
  } matchMode_e;

  // Strobes from control to datapath for the token in the decide stage
  typedef struct packed {
    logic memWr;      // write incoming value into the slot
    logic presSet;    // mark slot occupied
    logic presClr;    // mark slot empty
    logic fwd;        // issue operand pair to the ALU
    logic kill;       // absorb token
    logic useStored;  // partner operand comes from the slot
  } frameStrb_t;

endpackage

// File: rtl/opm_ctrl.sv
module opm_ctrl
  import opm_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              s1Valid,
  input  logic [2:0]        s1Mode,
  input  logic              s1Port,
  input  logic [SLOT_W-1:0] s1Ea,
  output frameStrb_t        strb
);

  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOTS-1:0] presBits;
  logic             slotFull;

  assign slotFull = presBits[s1Ea];

  always_comb begin
    strb = '0;
    if (s1Valid) begin
      case (s1Mode)
        MODE_NORMAL: begin
          if (slotFull) begin
            strb.fwd       = 1'b1;
            strb.useStored = 1'b1;
            strb.presClr   = 1'b1;
          end else begin
            strb.memWr   = 1'b1;
            strb.presSet = 1'b1;
            strb.kill    = 1'b1;
          end
        end
        MODE_STICKY: begin
          if (slotFull) begin
            strb.fwd       = 1'b1;
            strb.useStored = 1'b1;
          end else begin
            strb.memWr   = 1'b1;
            strb.presSet = 1'b1;
            strb.kill    = 1'b1;
          end
        end
        MODE_EXCHANGE: begin
          strb.memWr     = 1'b1;
          strb.presSet   = 1'b1;
          strb.fwd       = 1'b1;
          strb.useStored = 1'b1;
        end
        MODE_IMPERATIVE: begin
          if (s1Port) begin
            strb.fwd       = 1'b1;
            strb.useStored = 1'b1;
          end else begin
            strb.memWr   = 1'b1;
            strb.presSet = 1'b1;
            strb.kill    = 1'b1;
          end
        end
        default: strb.fwd = 1'b1;  // unary and unused codes bypass the frame
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presBits <= '0;
    end else if (strb.presSet) begin
      presBits[s1Ea] <= 1'b1;
    end else if (strb.presClr) begin
      presBits[s1Ea] <= 1'b0;
    end
  end

  // R4: a first normal arrival leaves the slot marked
  p_first_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid && s1Mode == MODE_NORMAL && !slotFull |=> presBits[$past(s1Ea)]);

  // R5: a normal match empties the slot
  p_match_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid && s1Mode == MODE_NORMAL && slotFull |=> !presBits[$past(s1Ea)]);

  // R7: a sticky match keeps the slot marked
  p_sticky_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid && s1Mode == MODE_STICKY && slotFull |=> presBits[$past(s1Ea)]);

  // R8: after an exchange the slot is marked
  p_xchg_present_r8: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid && s1Mode == MODE_EXCHANGE |=> presBits[$past(s1Ea)]);

endmodule

// File: rtl/opm_datapath.sv
module opm_datapath
  import opm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 6,
  parameter int IP_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SLOT_W-1:0] inFp,
  input  logic [IP_W-1:0]   inIp,
  input  logic              inPort,
  input  logic [DATA_W-1:0] inValue,
  input  logic [SLOT_W-1:0] inOffset,
  input  logic              inAbs,
  input  logic [2:0]        inMode,
  input  frameStrb_t        strb,
  output logic              s1Valid,
  output logic [2:0]        s1Mode,
  output logic              s1Port,
  output logic [SLOT_W-1:0] s1Ea,
  output logic              aluValid,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB,
  output logic [SLOT_W-1:0] aluFp,
  output logic [IP_W-1:0]   aluIp,
  output logic              tokKill
);

  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOT_W-1:0] effAddr;
  logic [SLOT_W-1:0] s1Fp;
  logic [IP_W-1:0]   s1Ip;
  logic [DATA_W-1:0] s1Value;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] partner;
  logic [DATA_W-1:0] nxtOpA;
  logic [DATA_W-1:0] nxtOpB;
  logic [DATA_W-1:0] frameMem [SLOTS];

  always_comb effAddr = inAbs ? inOffset : inFp + inOffset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) s1Valid <= 1'b0;
    else       s1Valid <= inValid;
  end

  always_ff @(posedge clk) begin
    if (inValid) begin
      s1Fp    <= inFp;
      s1Ip    <= inIp;
      s1Port  <= inPort;
      s1Value <= inValue;
      s1Mode  <= inMode;
      s1Ea    <= effAddr;
    end
  end

  // Synchronous frame RAM: read at acceptance, write at decide
  always_ff @(posedge clk) begin
    if (inValid) rdData <= frameMem[effAddr];
    if (strb.memWr) frameMem[s1Ea] <= s1Value;
  end

  always_comb begin
    partner = strb.useStored ? rdData : '0;
    nxtOpA  = s1Port ? partner : s1Value;
    nxtOpB  = s1Port ? s1Value : partner;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aluValid <= 1'b0;
      tokKill  <= 1'b0;
    end else begin
      aluValid <= strb.fwd;
      tokKill  <= strb.kill;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fwd) begin
      aluOpA <= nxtOpA;
      aluOpB <= nxtOpB;
      aluFp  <= s1Fp;
      aluIp  <= s1Ip;
    end
  end

  // R1: absolute addressing takes the offset as the slot
  p_abs_slot_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inAbs |=> s1Ea == $past(inOffset));

  // R1: frame-relative addressing adds the frame pointer
  p_frame_slot_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !inAbs |=> s1Ea == $past(inFp + inOffset));

  // R2: a token in decide yields exactly one outcome next cycle
  p_single_outcome_r2: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> $countones({aluValid, tokKill}) == 1);

  // R2: no outcome without a token
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> !aluValid && !tokKill);

  // R3: unary tokens never write the frame
  p_unary_frame_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid && (s1Mode == 3'd0 || s1Mode > 3'd4) |-> !strb.memWr && !strb.presSet && !strb.presClr);

endmodule

// File: rtl/opnd_match_stage.sv
module opnd_match_stage
  import opm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SLOT_W = 6,
  parameter int IP_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [SLOT_W-1:0] inFp,
  input  logic [IP_W-1:0]   inIp,
  input  logic              inPort,
  input  logic [DATA_W-1:0] inValue,
  input  logic [SLOT_W-1:0] inOffset,
  input  logic              inAbs,
  input  logic [2:0]        inMode,
  output logic              aluValid,
  output logic [DATA_W-1:0] aluOpA,
  output logic [DATA_W-1:0] aluOpB,
  output logic [SLOT_W-1:0] aluFp,
  output logic [IP_W-1:0]   aluIp,
  output logic              tokKill
);

  frameStrb_t        strb;
  logic              s1Valid;
  logic [2:0]        s1Mode;
  logic              s1Port;
  logic [SLOT_W-1:0] s1Ea;

  opm_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .s1Valid (s1Valid),
    .s1Mode  (s1Mode),
    .s1Port  (s1Port),
    .s1Ea    (s1Ea),
    .strb    (strb)
  );

  opm_datapath #(.DATA_W(DATA_W), .SLOT_W(SLOT_W), .IP_W(IP_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inFp     (inFp),
    .inIp     (inIp),
    .inPort   (inPort),
    .inValue  (inValue),
    .inOffset (inOffset),
    .inAbs    (inAbs),
    .inMode   (inMode),
    .strb     (strb),
    .s1Valid  (s1Valid),
    .s1Mode   (s1Mode),
    .s1Port   (s1Port),
    .s1Ea     (s1Ea),
    .aluValid (aluValid),
    .aluOpA   (aluOpA),
    .aluOpB   (aluOpB),
    .aluFp    (aluFp),
    .aluIp    (aluIp),
    .tokKill  (tokKill)
  );

endmodule

// File: tb/sim_opnd_match_stage.sv
`timescale 1ns/1ps
module sim_opnd_match_stage;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [5:0]  inFp = '0;
  logic [15:0] inIp = '0;
  logic        inPort = 1'b0;
  logic [31:0] inValue = '0;
  logic [5:0]  inOffset = '0;
  logic        inAbs = 1'b0;
  logic [2:0]  inMode = '0;
  logic        aluValid;
  logic [31:0] aluOpA;
  logic [31:0] aluOpB;
  logic [5:0]  aluFp;
  logic [15:0] aluIp;
  logic        tokKill;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  opnd_match_stage u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFp(inFp), .inIp(inIp),
    .inPort(inPort), .inValue(inValue), .inOffset(inOffset), .inAbs(inAbs),
    .inMode(inMode), .aluValid(aluValid), .aluOpA(aluOpA), .aluOpB(aluOpB),
    .aluFp(aluFp), .aluIp(aluIp), .tokKill(tokKill)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one token, then sample two edges after acceptance
  task automatic sendTok(input logic [2:0] mode, input logic abs, input logic [5:0] fp,
                         input logic [5:0] off, input logic port, input logic [31:0] val,
                         input logic [15:0] ip);
    @(negedge clk);
    inValid = 1'b1; inMode = mode; inAbs = abs; inFp = fp;
    inOffset = off; inPort = port; inValue = val; inIp = ip;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expKill(input string req);
    chk({req, " kill"}, {31'd0, tokKill}, 32'd1);
    chk({req, " novalid"}, {31'd0, aluValid}, 32'd0);
  endtask

  task automatic expFwd(input string req, input logic [31:0] a, input logic [31:0] b);
    chk({req, " valid"}, {31'd0, aluValid}, 32'd1);
    chk({req, " nokill"}, {31'd0, tokKill}, 32'd0);
    chk({req, " opA"}, aluOpA, a);
    chk({req, " opB"}, aluOpB, b);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 idle valid", {31'd0, aluValid}, 32'd0);
    chk("R10 idle kill", {31'd0, tokKill}, 32'd0);
    sendTok(3'd1, 1'b1, 6'd0, 6'd1, 1'b1, 32'hAB, 16'h1);
    expKill("R10 empty after reset");
    @(negedge clk);
    chk("R2 pulse ends", {31'd0, tokKill}, 32'd0);
  endtask

  task automatic t_unary();
    sendTok(3'd0, 1'b1, 6'd5, 6'd2, 1'b0, 32'h11, 16'h1234);
    expFwd("R3 unary port0", 32'h11, 32'h0);
    chk("R11 fp", {26'd0, aluFp}, 32'd5);
    chk("R11 ip", {16'd0, aluIp}, 32'h1234);
    sendTok(3'd6, 1'b1, 6'd0, 6'd2, 1'b1, 32'h22, 16'h2);
    expFwd("R3 unused code", 32'h0, 32'h22);
    sendTok(3'd1, 1'b1, 6'd0, 6'd3, 1'b0, 32'hA1, 16'h3);
    expKill("R4 store");
    sendTok(3'd0, 1'b1, 6'd0, 6'd3, 1'b1, 32'h99, 16'h4);
    expFwd("R3 bypass", 32'h0, 32'h99);
    sendTok(3'd1, 1'b1, 6'd0, 6'd3, 1'b1, 32'hB2, 16'h5);
    expFwd("R3 slot untouched", 32'hA1, 32'hB2);
  endtask

  task automatic t_normal();
    sendTok(3'd1, 1'b1, 6'd0, 6'd4, 1'b1, 32'h5, 16'h6);
    expKill("R4 right first");
    sendTok(3'd1, 1'b1, 6'd0, 6'd4, 1'b0, 32'h7, 16'h7);
    expFwd("R6 left second", 32'h7, 32'h5);
    sendTok(3'd1, 1'b1, 6'd0, 6'd4, 1'b0, 32'h8, 16'h8);
    expKill("R5 third stored again");
  endtask

  task automatic t_addr();
    sendTok(3'd1, 1'b0, 6'd10, 6'd3, 1'b0, 32'hC0, 16'h9);
    expKill("R1 frame store");
    sendTok(3'd1, 1'b1, 6'd0, 6'd13, 1'b1, 32'hC1, 16'hA);
    expFwd("R1 abs matches", 32'hC0, 32'hC1);
    sendTok(3'd1, 1'b0, 6'd60, 6'd10, 1'b0, 32'hD0, 16'hB);
    expKill("R1 wrap store");
    sendTok(3'd1, 1'b1, 6'd0, 6'd6, 1'b1, 32'hD1, 16'hC);
    expFwd("R1 wrap matches", 32'hD0, 32'hD1);
  endtask

  task automatic t_sticky();
    sendTok(3'd2, 1'b1, 6'd0, 6'd20, 1'b0, 32'h50, 16'hD);
    expKill("R7 first");
    sendTok(3'd2, 1'b1, 6'd0, 6'd20, 1'b1, 32'h51, 16'hE);
    expFwd("R7 second", 32'h50, 32'h51);
    sendTok(3'd2, 1'b1, 6'd0, 6'd20, 1'b1, 32'h52, 16'hF);
    expFwd("R7 third", 32'h50, 32'h52);
  endtask

  task automatic t_exchange();
    sendTok(3'd4, 1'b1, 6'd0, 6'd30, 1'b0, 32'h60, 16'h10);
    expKill("R9 seed");
    sendTok(3'd3, 1'b1, 6'd0, 6'd30, 1'b1, 32'h61, 16'h11);
    expFwd("R8 swap one", 32'h60, 32'h61);
    sendTok(3'd3, 1'b1, 6'd0, 6'd30, 1'b0, 32'h62, 16'h12);
    expFwd("R8 swap two", 32'h62, 32'h61);
    sendTok(3'd1, 1'b1, 6'd0, 6'd30, 1'b1, 32'h63, 16'h13);
    expFwd("R8 left present", 32'h62, 32'h63);
  endtask

  task automatic t_imperative();
    sendTok(3'd4, 1'b1, 6'd0, 6'd40, 1'b0, 32'h70, 16'h14);
    expKill("R9 write empty");
    sendTok(3'd4, 1'b1, 6'd0, 6'd40, 1'b0, 32'h71, 16'h15);
    expKill("R9 write full");
    sendTok(3'd4, 1'b1, 6'd0, 6'd40, 1'b1, 32'h72, 16'h16);
    expFwd("R9 read full", 32'h71, 32'h72);
    sendTok(3'd1, 1'b1, 6'd0, 6'd40, 1'b1, 32'h73, 16'h17);
    expFwd("R9 bit kept", 32'h71, 32'h73);
    sendTok(3'd4, 1'b1, 6'd0, 6'd40, 1'b1, 32'h74, 16'h18);
    expFwd("R9 read empty", 32'h71, 32'h74);
    sendTok(3'd1, 1'b1, 6'd0, 6'd40, 1'b0, 32'h75, 16'h19);
    expKill("R9 bit still clear");
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_unary();
    t_normal();
    t_addr();
    t_sticky();
    t_exchange();
    t_imperative();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

endmodule